// File: doc/BRIEF.md
# Multi-Rail Power Sequencer with Fault Groups

This block drives the enable pins of a set of power rails and brings them up and down in a configured order. All timing is counted in ticks of a slow shared timebase, so several copies of the block on one board stay in step. Each rail has its own turn-on delay, turn-off delay, power-good timeout, dependency mask (the rails that must be good before it may start) and fault-group mask.

A power-up request starts the up sequence. A rail waits for its dependencies, waits out its turn-on delay, is enabled, and then must show power-good before its timeout. A rail that fails, whether it never started or was never released by its dependencies, faults every rail that shares one of its groups. A power-down request runs a separate sequence with its own per-rail delays. A wired-AND fault-share line links several sequencers: the block pulls it low when a shared group aborts, and it aborts its own shared groups when another device pulls the line low.

The sequencer states are IDLE, UP, RUN and DOWN. IDLE goes to UP on a power-up request. UP goes to RUN once every rail is on or faulted, and to DOWN on a power-down request. RUN goes to DOWN on a power-down request. DOWN goes to IDLE when every rail is off. Each rail steps through OFF, DEP (waiting for dependencies), DLY (turn-on delay), RAMP (enabled, waiting for power-good), ON, DOWN (turn-off delay) and FAULT.

Top module: `rail_sequencer`

## Requirements
- R1: After reset every enable is low, every rail status is 0, the sticky fault bits are clear, `seq_state` is 0 and `fshare_drive` is low. While `seq_state` is 0, no rail is enabled.
- R2: Take the edge at which a rail in DEP first sees all the rails in its dependency mask reporting power-good, with a tick on every cycle. The rail's enable rises `on_dly`+1 clock edges after that edge. A rail with an empty mask takes that step one edge after the power-up command edge.
- R3: Delays and timeouts advance only on cycles where `tick` is high. With `tick` held low, a rail in its turn-on delay stays disabled.
- R4: A power-down command in UP or RUN drops each enabled rail's enable `off_dly`+1 edges after the command edge. Rails that were never enabled or are faulted go to status 0 at once. `seq_state` returns to 0 on the edge after the last rail turns off.
- R5: A power-up command received while `seq_state` is 3 has no effect.
- R6: An enabled rail that has not shown power-good `pg_tmo` ticks after enabling becomes faulted (status 3) on the following edge, and its enable drops.
- R7: A rail whose dependencies are not met within `pg_tmo` ticks of the power-up command is faulted in the same way. A dependency loop therefore cannot stall the sequencer, and it still reaches `seq_state` 2.
- R8: When a rail faults on its own, every rail sharing a fault group with it becomes faulted on the next edge. Rails in other groups are unaffected.
- R9: `fshare_drive` goes high once a group selected by `cfg_share_map` has had its own fault, and it stays high until the sequencer is back in state 0.
- R10: With the sequence in state 1 or 2, a low level on `fshare_in` before an edge faults, one edge later, the rails in groups selected by `cfg_share_map`. It does not raise `fshare_drive`.
- R11: `rail_status` holds 2 bits per rail, with rail i at bits [2i+1:2i]: 0 off, 1 waiting/ramping, 2 on (including the turn-off delay), 3 faulted.
- R12: `fault_sticky[i]` sets on the edge at which rail i enters the faulted state. It clears when `fault_clr[i]` is high on an edge. If both happen on the same edge, the set wins.
- R13: `seq_state` encodes 0 IDLE, 1 UP, 2 RUN, 3 DOWN. UP moves to RUN on the edge after every rail is on or faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared timebase strobe, one cycle per tick |
| cmd_on | input | 1 | Power-up request pulse |
| cmd_off | input | 1 | Power-down request pulse |
| pg | input | N_RAILS | Power-good per rail |
| cfg_on_dly | input | N_RAILS*CNT_W | Turn-on delays in ticks |
| cfg_off_dly | input | N_RAILS*CNT_W | Turn-off delays in ticks |
| cfg_pg_tmo | input | N_RAILS*CNT_W | Start timeout per rail in ticks |
| cfg_dep | input | N_RAILS*N_RAILS | Dependency mask per rail, rail i in bits [i*N_RAILS +: N_RAILS] |
| cfg_grp | input | N_RAILS*N_GROUPS | Fault-group membership per rail |
| cfg_share_map | input | N_GROUPS | Groups tied to the fault-share line |
| fault_clr | input | N_RAILS | Write-one-to-clear for sticky faults |
| fshare_in | input | 1 | Level sensed on the wired fault-share line |
| fshare_drive | output | 1 | High to pull the fault-share line low |
| rail_en | output | N_RAILS | Rail enables |
| rail_status | output | 2*N_RAILS | Per-rail status code |
| fault_sticky | output | N_RAILS | Sticky fault bits |
| seq_state | output | 2 | Sequencer state code |

## Verification
Two things can land on the same clock edge: a rail entering the faulted state and software clearing that rail's sticky bit. The bench creates the collision with an external fault-share pull. That pull turns into a group abort on a known edge, and the bench raises `fault_clr` for the same rails on exactly that edge. It then expects the sticky bits to read as set, with the faulted status showing at that edge and not one earlier. A second overlap is a power-up command arriving during the power-down sequence: the bench checks that the state stays in DOWN and that the turn-off edges are unchanged.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_UP   = 2'd1,
        SQ_RUN  = 2'd2,
        SQ_DOWN = 2'd3
    } seq_st_t;

    typedef enum logic [2:0] {
        RL_OFF   = 3'd0,
        RL_DEP   = 3'd1,
        RL_DLY   = 3'd2,
        RL_RAMP  = 3'd3,
        RL_ON    = 3'd4,
        RL_DOWN  = 3'd5,
        RL_FAULT = 3'd6
    } rail_st_t;

    localparam logic [1:0] STAT_OFF   = 2'd0;
    localparam logic [1:0] STAT_WAIT  = 2'd1;
    localparam logic [1:0] STAT_ON    = 2'd2;
    localparam logic [1:0] STAT_FAULT = 2'd3;

endpackage

// File: rtl/seq_rail_ctrl.sv
module seq_rail_ctrl
    import seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go_up,
    input  logic             go_down,
    input  logic             active,
    input  logic             deps_ok,
    input  logic             pg,
    input  logic             abort,
    input  logic [CNT_W-1:0] on_dly,
    input  logic [CNT_W-1:0] off_dly,
    input  logic [CNT_W-1:0] pg_tmo,
    output logic             en,
    output logic [1:0]       status,
    output logic             own_fail,
    output logic             fault_evt,
    output logic             settled,
    output logic             is_off
);

    rail_st_t         st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx, cnt_inc;

    assign cnt_inc = cnt + {{(CNT_W-1){1'b0}}, tick};

    // next-state logic
    always_comb begin
        st_nx    = st;
        cnt_nx   = cnt;
        own_fail = 1'b0;
        unique case (st)
            RL_OFF: ;
            RL_DEP: begin
                if (deps_ok) begin
                    st_nx  = RL_DLY;
                    cnt_nx = '0;
                end else if (cnt >= pg_tmo) begin
                    st_nx    = RL_FAULT;
                    own_fail = 1'b1;
                end else begin
                    cnt_nx = cnt_inc;
                end
            end
            RL_DLY: begin
                if (cnt >= on_dly) begin
                    st_nx  = RL_RAMP;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt_inc;
                end
            end
            RL_RAMP: begin
                if (pg) begin
                    st_nx = RL_ON;
                end else if (cnt >= pg_tmo) begin
                    st_nx    = RL_FAULT;
                    own_fail = 1'b1;
                end else begin
                    cnt_nx = cnt_inc;
                end
            end
            RL_ON: ;
            RL_DOWN: begin
                if (cnt >= off_dly) st_nx = RL_OFF;
                else                cnt_nx = cnt_inc;
            end
            RL_FAULT: ;
            default: st_nx = RL_OFF;
        endcase
        if (active && abort &&
            (st inside {RL_DEP, RL_DLY, RL_RAMP, RL_ON}))
            st_nx = RL_FAULT;
        if (go_up) begin
            st_nx    = RL_DEP;
            cnt_nx   = '0;
            own_fail = 1'b0;
        end
        if (go_down) begin
            st_nx    = (st inside {RL_RAMP, RL_ON}) ? RL_DOWN : RL_OFF;
            cnt_nx   = '0;
            own_fail = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= RL_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        en        = st inside {RL_RAMP, RL_ON, RL_DOWN};
        settled   = st inside {RL_ON, RL_FAULT};
        is_off    = (st == RL_OFF);
        fault_evt = (st_nx == RL_FAULT) && (st != RL_FAULT);
        unique case (st)
            RL_OFF:                  status = STAT_OFF;
            RL_DEP, RL_DLY, RL_RAMP: status = STAT_WAIT;
            RL_ON, RL_DOWN:          status = STAT_ON;
            RL_FAULT:                status = STAT_FAULT;
            default:                 status = STAT_OFF;
        endcase
    end

    a_r4_down_entry: assert property (@(posedge clk) disable iff (!rst_n)
        go_down |=> (st inside {RL_OFF, RL_DOWN}));

    a_r8_abort_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (active && abort && !go_down && !go_up &&
         (st inside {RL_DEP, RL_DLY, RL_RAMP, RL_ON})) |=> (st == RL_FAULT));

    a_r3_no_tick_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !go_down && !abort && st == RL_DLY && cnt < on_dly)
            |=> $stable(cnt));

endmodule

// File: rtl/seq_fault_groups.sv
module seq_fault_groups #(
    parameter int N_RAILS  = 4,
    parameter int N_GROUPS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         active,
    input  logic [N_RAILS-1:0]           own_fail,
    input  logic [N_RAILS*N_GROUPS-1:0]  rail_grp,
    input  logic [N_GROUPS-1:0]          share_map,
    input  logic                         fshare_in,
    output logic [N_RAILS-1:0]           rail_abort,
    output logic                         drive_low
);

    logic [N_GROUPS-1:0] grp_own, grp_ext, grp_fault;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic [N_RAILS-1:0] members;
        for (genvar i = 0; i < N_RAILS; i++) begin : g_mem
            assign members[i] = rail_grp[i*N_GROUPS + g];
        end

        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                grp_own[g] <= 1'b0;
                grp_ext[g] <= 1'b0;
            end else begin
                grp_own[g] <= grp_own[g] | (active & (|(own_fail & members)));
                grp_ext[g] <= grp_ext[g] | (active & share_map[g] & ~fshare_in);
            end
        end

        a_r10_ext_latch: assert property (@(posedge clk) disable iff (!rst_n)
            (active && !clear && share_map[g] && !fshare_in) |=> grp_ext[g]);
    end

    assign grp_fault = grp_own | grp_ext;
    assign drive_low = |(grp_own & share_map);

    for (genvar i = 0; i < N_RAILS; i++) begin : g_abort
        assign rail_abort[i] = |(grp_fault & rail_grp[i*N_GROUPS +: N_GROUPS]);
    end

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import seq_pkg::*;
#(
    parameter int N_RAILS  = 4,
    parameter int N_GROUPS = 2,
    parameter int CNT_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic                         cmd_on,
    input  logic                         cmd_off,
    input  logic [N_RAILS-1:0]           pg,
    input  logic [N_RAILS*CNT_W-1:0]     cfg_on_dly,
    input  logic [N_RAILS*CNT_W-1:0]     cfg_off_dly,
    input  logic [N_RAILS*CNT_W-1:0]     cfg_pg_tmo,
    input  logic [N_RAILS*N_RAILS-1:0]   cfg_dep,
    input  logic [N_RAILS*N_GROUPS-1:0]  cfg_grp,
    input  logic [N_GROUPS-1:0]          cfg_share_map,
    input  logic [N_RAILS-1:0]           fault_clr,
    input  logic                         fshare_in,
    output logic                         fshare_drive,
    output logic [N_RAILS-1:0]           rail_en,
    output logic [2*N_RAILS-1:0]         rail_status,
    output logic [N_RAILS-1:0]           fault_sticky,
    output logic [1:0]                   seq_state
);

    seq_st_t            state, state_nx;
    logic               go_up, go_down, active, idle;
    logic [N_RAILS-1:0] settled, is_off, own_fail, fault_evt, rail_abort;
    logic               all_settled, all_off, drive_low;

    assign all_settled = &settled;
    assign all_off     = &is_off;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE: if (cmd_on)           state_nx = SQ_UP;
            SQ_UP:   if (cmd_off)          state_nx = SQ_DOWN;
                     else if (all_settled) state_nx = SQ_RUN;
            SQ_RUN:  if (cmd_off)          state_nx = SQ_DOWN;
            SQ_DOWN: if (all_off)          state_nx = SQ_IDLE;
            default:                       state_nx = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    // outputs and rail controls
    always_comb begin
        idle         = (state == SQ_IDLE);
        active       = (state == SQ_UP) || (state == SQ_RUN);
        go_up        = idle && cmd_on;
        go_down      = active && cmd_off;
        fshare_drive = !idle && drive_low;
        seq_state    = state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fault_sticky <= '0;
        else        fault_sticky <= (fault_sticky & ~fault_clr) | fault_evt;
    end

    for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
        logic dep_ok;
        assign dep_ok = &(~cfg_dep[i*N_RAILS +: N_RAILS] | pg);

        seq_rail_ctrl #(.CNT_W(CNT_W)) u_rail (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .go_up     (go_up),
            .go_down   (go_down),
            .active    (active),
            .deps_ok   (dep_ok),
            .pg        (pg[i]),
            .abort     (rail_abort[i]),
            .on_dly    (cfg_on_dly[i*CNT_W +: CNT_W]),
            .off_dly   (cfg_off_dly[i*CNT_W +: CNT_W]),
            .pg_tmo    (cfg_pg_tmo[i*CNT_W +: CNT_W]),
            .en        (rail_en[i]),
            .status    (rail_status[2*i +: 2]),
            .own_fail  (own_fail[i]),
            .fault_evt (fault_evt[i]),
            .settled   (settled[i]),
            .is_off    (is_off[i])
        );

        a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            fault_evt[i] |=> fault_sticky[i]);
    end

    seq_fault_groups #(.N_RAILS(N_RAILS), .N_GROUPS(N_GROUPS)) u_groups (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (idle),
        .active     (active),
        .own_fail   (own_fail),
        .rail_grp   (cfg_grp),
        .share_map  (cfg_share_map),
        .fshare_in  (fshare_in),
        .rail_abort (rail_abort),
        .drive_low  (drive_low)
    );

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE) |-> (rail_en == '0));

    a_r5_on_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_DOWN) |=> (state inside {SQ_DOWN, SQ_IDLE}));

    a_r13_run_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_RUN) |-> all_settled);

endmodule

// File: tb/test_rail_sequencer.sv
`timescale 1ns/1ps
module test_rail_sequencer;

    localparam int N = 4;
    localparam int G = 2;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic cmd_on = 1'b0, cmd_off = 1'b0;
    logic [N-1:0] pg, pg_d1, broken = '0, fault_clr = '0;
    logic ext_pull = 1'b0;
    logic [15:0] on_d [N], off_d [N], tmo_d [N];
    logic [N-1:0] dep_d [N];
    logic [G-1:0] grp_d [N];
    logic [N*W-1:0] cfg_on_dly, cfg_off_dly, cfg_pg_tmo;
    logic [N*N-1:0] cfg_dep;
    logic [N*G-1:0] cfg_grp;
    logic [G-1:0]   cfg_share_map = 2'b10;
    logic fshare_in, fshare_drive;
    logic [N-1:0] rail_en, fault_sticky;
    logic [2*N-1:0] rail_status;
    logic [1:0] seq_state;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cfg_on_dly[i*W +: W]  = on_d[i];
            cfg_off_dly[i*W +: W] = off_d[i];
            cfg_pg_tmo[i*W +: W]  = tmo_d[i];
            cfg_dep[i*N +: N]     = dep_d[i];
            cfg_grp[i*G +: G]     = grp_d[i];
        end
    end

    assign fshare_in = ~(fshare_drive | ext_pull);

    // power-good model: two cycles after enable, unless the rail is broken
    always @(posedge clk) begin
        if (!rst_n) begin
            pg_d1 <= '0;
            pg    <= '0;
        end else begin
            pg_d1 <= rail_en & ~broken;
            pg    <= pg_d1;
        end
    end

    rail_sequencer #(.N_RAILS(N), .N_GROUPS(G), .CNT_W(W)) i_rail_sequencer (
        .clk, .rst_n, .tick, .cmd_on, .cmd_off, .pg,
        .cfg_on_dly, .cfg_off_dly, .cfg_pg_tmo, .cfg_dep, .cfg_grp,
        .cfg_share_map, .fault_clr, .fshare_in, .fshare_drive,
        .rail_en, .rail_status, .fault_sticky, .seq_state
    );

    // edge counter and event recorder (sampled at negedge)
    int cyc = 0;
    int rise_at [N], fall_at [N], fault_at [N];
    logic [N-1:0] en_q = '0;
    logic [2*N-1:0] st_q = '0;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rail_en[i] && !en_q[i]) rise_at[i] = cyc;
            if (!rail_en[i] && en_q[i]) fall_at[i] = cyc;
            if (rail_status[2*i +: 2] == 2'd3 && st_q[2*i +: 2] != 2'd3)
                fault_at[i] = cyc;
        end
        en_q = rail_en;
        st_q = rail_status;
    end

    // scoreboard
    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
        logic [31:0] act;
    } item_t;
    item_t sb_q [$];
    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic expect_val(string tag, int sel, logic [31:0] exp,
                              logic [31:0] act = 32'd0);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp; it.act = act;
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = sb_q.pop_front();
            case (it.sel)
                0:       got = 32'(rail_en);
                1:       got = 32'(rail_status);
                2:       got = 32'(fault_sticky);
                3:       got = 32'(seq_state);
                4:       got = 32'(fshare_drive);
                default: got = it.act;
            endcase
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %0h expected %0h", it.tag, got, it.exp);
            end
        end
    end

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_on();
        cmd_on = 1'b1;
        step(1);
        cmd_on = 1'b0;
    endtask

    task automatic pulse_off();
        cmd_off = 1'b1;
        step(1);
        cmd_off = 1'b0;
    endtask

    task automatic finish_run();
        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int e0;
        on_d  = '{16'd2, 16'd1, 16'd3, 16'd0};
        off_d = '{16'd5, 16'd3, 16'd1, 16'd0};
        tmo_d = '{16'd20, 16'd20, 16'd14, 16'd60};
        dep_d = '{4'b0000, 4'b0001, 4'b0010, 4'b0101};
        grp_d = '{2'b01, 2'b01, 2'b10, 2'b10};
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        expect_val("R1 en", 0, 0);
        expect_val("R1 status", 1, 0);
        expect_val("R1 sticky", 2, 0);
        expect_val("R1 state", 3, 0);
        expect_val("R1 drive", 4, 0);
        step(1);

        // R2/R13 ordered power-up
        pulse_on();
        e0 = cyc;
        expect_val("R13 state UP", 3, 1);
        step(30);
        expect_val("R2 rail0 rise", 5, 4,  32'(rise_at[0] - e0));
        expect_val("R2 rail1 rise", 5, 9,  32'(rise_at[1] - e0));
        expect_val("R2 rail2 rise", 5, 16, 32'(rise_at[2] - e0));
        expect_val("R2 rail3 rise", 5, 20, 32'(rise_at[3] - e0));
        expect_val("R13 state RUN", 3, 2);
        expect_val("R11 all on", 1, 32'hAA);
        expect_val("R2 all enabled", 0, 32'hF);

        // R4/R5 power-down, power-up request ignored mid-sequence
        pulse_off();
        e0 = cyc;
        step(2);
        cmd_on = 1'b1;
        step(1);
        cmd_on = 1'b0;
        expect_val("R5 stays DOWN", 3, 3);
        step(7);
        expect_val("R4 rail3 fall", 5, 1, 32'(fall_at[3] - e0));
        expect_val("R4 rail2 fall", 5, 2, 32'(fall_at[2] - e0));
        expect_val("R4 rail1 fall", 5, 4, 32'(fall_at[1] - e0));
        expect_val("R4 rail0 fall", 5, 6, 32'(fall_at[0] - e0));
        expect_val("R4 idle", 3, 0);
        expect_val("R5 no enables", 0, 0);
        expect_val("R1 status idle", 1, 0);

        // R6/R8/R9 timeout in a shared group
        broken[2] = 1'b1;
        step(1);
        pulse_on();
        e0 = cyc;
        step(40);
        expect_val("R6 rail2 fault edge", 5, 31, 32'(fault_at[2] - e0));
        expect_val("R8 rail3 abort edge", 5, 32, 32'(fault_at[3] - e0));
        expect_val("R8 status", 1, 32'hFA);
        expect_val("R8 enables", 0, 32'h3);
        expect_val("R12 sticky set", 2, 32'hC);
        expect_val("R9 drive", 4, 1);
        expect_val("R13 settles RUN", 3, 2);

        pulse_off();
        e0 = cyc;
        step(10);
        expect_val("R4 faulted down rail1", 5, 4, 32'(fall_at[1] - e0));
        expect_val("R9 drive released", 4, 0);
        expect_val("R4 idle after fault", 3, 0);
        expect_val("R12 sticky kept", 2, 32'hC);

        // R12 write-one-clear
        fault_clr = 4'b0100;
        step(1);
        fault_clr = '0;
        expect_val("R12 clear one", 2, 32'h8);
        fault_clr = 4'b1111;
        step(1);
        fault_clr = '0;
        expect_val("R12 clear all", 2, 32'h0);

        // R10 + R12 collision: external pull, clear on the fault edge
        broken = '0;
        step(1);
        pulse_on();
        step(30);
        expect_val("R13 RUN again", 3, 2);
        ext_pull = 1'b1;
        step(1);
        expect_val("R10 not yet", 1, 32'hAA);
        fault_clr = 4'b1100;
        step(1);
        fault_clr = '0;
        ext_pull = 1'b0;
        expect_val("R10 status", 1, 32'hFA);
        expect_val("R12 set wins", 2, 32'hC);
        expect_val("R10 enables", 0, 32'h3);
        expect_val("R10 no drive", 4, 0);
        step(1);

        // R7 dependency loop
        pulse_off();
        step(10);
        fault_clr = 4'b1111;
        dep_d = '{4'b0010, 4'b0001, 4'b0000, 4'b0000};
        tmo_d[0] = 16'd10;
        step(1);
        fault_clr = '0;
        pulse_on();
        e0 = cyc;
        step(20);
        expect_val("R7 rail0 fault edge", 5, 11, 32'(fault_at[0] - e0));
        expect_val("R8 rail1 abort edge", 5, 12, 32'(fault_at[1] - e0));
        expect_val("R7 status", 1, 32'hAF);
        expect_val("R7 reaches RUN", 3, 2);
        expect_val("R9 unshared no drive", 4, 0);
        expect_val("R12 sticky loop", 2, 32'h3);

        // R3 tick gating
        pulse_off();
        step(10);
        dep_d = '{4'b0000, 4'b0001, 4'b0010, 4'b0101};
        tmo_d[0] = 16'd20;
        tick = 1'b0;
        step(1);
        pulse_on();
        e0 = cyc;
        step(20);
        expect_val("R3 no tick no enable", 0, 0);
        tick = 1'b1;
        step(5);
        expect_val("R3 rail0 rise after ticks", 5, 23, 32'(rise_at[0] - e0));

        done = 1'b1;
        finish_run();
    end

endmodule